// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block is the multi-cycle controller that carries out the memory-moving instructions of a small 16-bit word-addressed processor: plain loads and stores, loads and stores through a pointer in memory, loads and stores relative to a base register, and the load-effective-address operation. It accepts one instruction word and the already-incremented program counter with a single-cycle `start` pulse. It then works out the effective address, steps an internal memory address register (MAR) and memory data register (MDR) through one or two memory transactions, and finally writes the result back to the register file.

The effective address is either the incremented PC plus a sign-extended 9-bit field, or a base register plus a sign-extended 6-bit field. Indirect forms read a pointer word first and use it as the final address. The effective-address form writes the address itself and never touches memory. Every value written to a register also refreshes the negative, zero and positive condition flags. Memory is reached through a request/acknowledge port, and the request is held until it is acknowledged. The register file is reached through one combinational read port and one write port. Fetch and arithmetic are done elsewhere.

Top module: `ldst_addr_seq`

## Requirements
- R1: For opcodes 0010 (load) and 0011 (store), the memory address is `npc` plus `instr[8:0]` sign-extended. For example, `npc` = x4012 with field 101000010 gives address x3F54.
- R2: For opcodes 0110 (base load) and 0111 (base store), the memory address is the register named by `instr[8:6]` plus `instr[5:0]` sign-extended.
- R3: For opcodes 1010 (indirect load) and 1011 (indirect store), a read is first made at the R1 address, and the data access then uses the word returned by that read as its address.
- R4: Opcode 1110 writes `npc` plus sign-extended `instr[8:0]` to the register `instr[11:9]`, makes no memory request, and asserts `done` in the second cycle after the `start` edge.
- R5: Every load form writes the data word read from memory to the register named by `instr[11:9]`, and writes exactly once.
- R6: Every store form writes the register named by `instr[11:9]` (`mem_we`=1) to its address and makes no register-file write.
- R7: After any register write, flags {N,Z,P} are set from the written value: N = bit 15, Z = value zero, P = neither. Stores leave the flags unchanged, and exactly one flag is always set.
- R8: While `mem_req` is high and `mem_ack` is low, the request, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle per accepted instruction. `busy` is high from the cycle after the accepting edge until `done`.
- R10: A `start` pulse is ignored while `busy` is high, or when `instr[15:12]` is not one of the seven opcodes above.
- R11: After reset, `busy`, `done`, `mem_req` and `rf_wr_en` are low, and the flags are {N,Z,P} = 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept `instr` and `npc` when idle |
| instr | input | 16 | Instruction word |
| npc | input | DW | Incremented program counter |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_idx | output | RW | Register-file read index |
| rf_rd_data | input | DW | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | RW | Register-file write index |
| rf_wr_data | output | DW | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | DW | Memory address (MAR) |
| mem_wdata | output | DW | Memory write data (MDR) |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
The bench builds the block with its defaults, DW = 16 and RW = 3, so that random PC values and offsets exercise sign extension and address wrap-around across the full 16-bit space. A memory model with a random acknowledge latency of zero to two cycles, and pointer words computed by a hash of the address, covers held requests and two-step indirect chains. Directed cases cover the known x3F54 address, a zero and a negative effective address, a `start` pulse arriving mid-instruction, and undefined opcodes.

// File: rtl/ldst_pkg.sv
// Shared definitions for the load/store address sequencer.
// Assumes a 16-bit instruction word with the opcode in bits [15:12].
package ldst_pkg;
    localparam int INSN_W  = 16;
    localparam int OFF9_W  = 9;
    localparam int OFF6_W  = 6;

    localparam logic [3:0] OPC_LD  = 4'b0010;
    localparam logic [3:0] OPC_ST  = 4'b0011;
    localparam logic [3:0] OPC_LDI = 4'b1010;
    localparam logic [3:0] OPC_STI = 4'b1011;
    localparam logic [3:0] OPC_LDR = 4'b0110;
    localparam logic [3:0] OPC_STR = 4'b0111;
    localparam logic [3:0] OPC_LEA = 4'b1110;

    // Decoded character of one memory-moving instruction.
    typedef struct packed {
        logic valid;
        logic is_store;
        logic is_lea;
        logic indirect;
        logic base_mode;
    } op_class_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_PTR_RD,
        SQ_PTR_MV,
        SQ_SRC,
        SQ_ACC,
        SQ_WB
    } seq_state_t;
endpackage

// File: rtl/ldst_decode.sv
// Opcode classifier: maps a 4-bit opcode onto the addressing attributes
// the sequencer needs. Purely combinational. Unknown opcodes give valid=0.
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [3:0] opc,
    output op_class_t  cls
);
    // Classify the opcode into mode flags.
    always_comb begin
        cls = '0;
        case (opc)
            OPC_LD:  cls = '{valid: 1'b1, is_store: 1'b0, is_lea: 1'b0, indirect: 1'b0, base_mode: 1'b0};
            OPC_ST:  cls = '{valid: 1'b1, is_store: 1'b1, is_lea: 1'b0, indirect: 1'b0, base_mode: 1'b0};
            OPC_LDI: cls = '{valid: 1'b1, is_store: 1'b0, is_lea: 1'b0, indirect: 1'b1, base_mode: 1'b0};
            OPC_STI: cls = '{valid: 1'b1, is_store: 1'b1, is_lea: 1'b0, indirect: 1'b1, base_mode: 1'b0};
            OPC_LDR: cls = '{valid: 1'b1, is_store: 1'b0, is_lea: 1'b0, indirect: 1'b0, base_mode: 1'b1};
            OPC_STR: cls = '{valid: 1'b1, is_store: 1'b1, is_lea: 1'b0, indirect: 1'b0, base_mode: 1'b1};
            OPC_LEA: cls = '{valid: 1'b1, is_store: 1'b0, is_lea: 1'b1, indirect: 1'b0, base_mode: 1'b0};
            default: cls = '0;
        endcase
    end
endmodule

// File: rtl/ldst_agen.sv
// Effective-address generator: either PC-relative (9-bit signed field) or
// base-plus-offset (6-bit signed field). Combinational; the caller registers
// the result into MAR. Assumes DW >= 16.
module ldst_agen
    import ldst_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]     npc,
    input  logic [DW-1:0]     base,
    input  logic [OFF9_W-1:0] off_field,
    input  logic              use_base,
    output logic [DW-1:0]     ea
);
    logic [DW-1:0] sx_long;
    logic [DW-1:0] sx_short;

    // Sign-extend both offset widths and pick the operand pair.
    always_comb begin
        sx_long  = {{(DW-OFF9_W){off_field[OFF9_W-1]}}, off_field};
        sx_short = {{(DW-OFF6_W){off_field[OFF6_W-1]}}, off_field[OFF6_W-1:0]};
        ea       = use_base ? (base + sx_short) : (npc + sx_long);
    end
endmodule

// File: rtl/ldst_flags.sv
// Condition flag register: N, Z, P refreshed from every register-file write,
// held otherwise. Reset value is Z set.
module ldst_flags #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_p
);
    logic neg;
    logic zero;

    // Classify the value being written.
    always_comb begin
        neg  = wr_data[DW-1];
        zero = (wr_data == '0);
    end

    // Update the flags on a write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b1;
            flag_p <= 1'b0;
        end else if (wr_en) begin
            flag_n <= neg;
            flag_z <= zero;
            flag_p <= !neg && !zero;
        end
    end

    // R7
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({flag_n, flag_z, flag_p}));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({flag_n, flag_z, flag_p}));
endmodule

// File: rtl/ldst_addr_seq.sv
// Load/store address sequencer. Accepts one memory-moving instruction on
// start while idle, then walks MAR/MDR through zero, one or two memory
// transactions and a final write-back. Assumes rf_rd_data is a
// combinational function of rf_rd_idx and that mem_rdata is valid with mem_ack.
module ldst_addr_seq
    import ldst_pkg::*;
#(
    parameter int DW = 16,
    parameter int RW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [INSN_W-1:0] instr,
    input  logic [DW-1:0]     npc,
    output logic              busy,
    output logic              done,
    output logic [RW-1:0]     rf_rd_idx,
    input  logic [DW-1:0]     rf_rd_data,
    output logic              rf_wr_en,
    output logic [RW-1:0]     rf_wr_idx,
    output logic [DW-1:0]     rf_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p
);
    localparam int REG_LO  = OFF6_W;            // base register field low bit
    localparam int DST_LO  = OFF9_W;            // dest/source field low bit
    localparam int FIELD_W = DST_LO + RW;       // instruction bits kept

    seq_state_t          st;
    op_class_t           cls_in;
    op_class_t           cls;
    logic [FIELD_W-1:0]  ir;
    logic [DW-1:0]       npc_q;
    logic [DW-1:0]       mar;
    logic [DW-1:0]       mdr;
    logic [DW-1:0]       ea;
    logic                accept;

    ldst_decode u_dec (
        .opc (instr[INSN_W-1:INSN_W-4]),
        .cls (cls_in)
    );

    ldst_agen #(.DW(DW)) u_agen (
        .npc       (npc_q),
        .base      (rf_rd_data),
        .off_field (ir[OFF9_W-1:0]),
        .use_base  (cls.base_mode),
        .ea        (ea)
    );

    // Acceptance of a new instruction: idle and a known opcode.
    always_comb accept = start && (st == SQ_IDLE) && cls_in.valid;

    // Sequencer state, instruction capture, MAR and MDR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_IDLE;
            cls   <= '0;
            ir    <= '0;
            npc_q <= '0;
            mar   <= '0;
            mdr   <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (accept) begin
                        ir    <= instr[FIELD_W-1:0];
                        npc_q <= npc;
                        cls   <= cls_in;
                        st    <= SQ_ADDR;
                    end
                end
                SQ_ADDR: begin
                    mar <= ea;
                    if (cls.is_lea)        st <= SQ_WB;
                    else if (cls.indirect) st <= SQ_PTR_RD;
                    else if (cls.is_store) st <= SQ_SRC;
                    else                   st <= SQ_ACC;
                end
                SQ_PTR_RD: begin
                    if (mem_ack) begin
                        mdr <= mem_rdata;
                        st  <= SQ_PTR_MV;
                    end
                end
                SQ_PTR_MV: begin
                    mar <= mdr;
                    st  <= cls.is_store ? SQ_SRC : SQ_ACC;
                end
                SQ_SRC: begin
                    mdr <= rf_rd_data;
                    st  <= SQ_ACC;
                end
                SQ_ACC: begin
                    if (mem_ack) begin
                        if (!cls.is_store) mdr <= mem_rdata;
                        st <= SQ_WB;
                    end
                end
                SQ_WB:   st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Port-side decoding of the current step.
    always_comb begin
        busy       = (st != SQ_IDLE);
        done       = (st == SQ_WB);
        mem_req    = (st == SQ_PTR_RD) || (st == SQ_ACC);
        mem_we     = (st == SQ_ACC) && cls.is_store;
        mem_addr   = mar;
        mem_wdata  = mdr;
        rf_rd_idx  = (st == SQ_ADDR) ? ir[REG_LO +: RW] : ir[DST_LO +: RW];
        rf_wr_en   = (st == SQ_WB) && !cls.is_store;
        rf_wr_idx  = ir[DST_LO +: RW];
        rf_wr_data = cls.is_lea ? mar : mdr;
    end

    ldst_flags #(.DW(DW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_wr_en),
        .wr_data (rf_wr_data),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .flag_p  (flag_p)
    );

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    lea_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cls.is_lea) |-> !mem_req);

    // R6
    store_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !rf_wr_en);

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/ldst_addr_seq_bench.sv
`timescale 1ns/1ps
module ldst_addr_seq_bench;
    localparam int DW = 16;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   instr = '0;
    logic [DW-1:0] npc = '0;
    logic          busy, done, rf_wr_en, mem_req, mem_we;
    logic [RW-1:0] rf_rd_idx, rf_wr_idx;
    logic [DW-1:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          flag_n, flag_z, flag_p;

    logic [DW-1:0] regs [8];
    logic [2:0]    exp_fl;
    int            tests = 0;
    int            fails = 0;
    int            lat = 0;

    always #4 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_idx];

    ldst_addr_seq #(.DW(DW), .RW(RW)) u_ldst_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .npc(npc),
        .busy(busy), .done(done), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    function automatic logic [15:0] mword(input logic [15:0] a);
        return (a * 16'h9E37) ^ 16'h3C5A;
    endfunction
    function automatic logic [15:0] sx9(input logic [8:0] f);
        return {{7{f[8]}}, f};
    endfunction
    function automatic logic [15:0] sx6(input logic [5:0] f);
        return {{10{f[5]}}, f};
    endfunction
    function automatic logic [2:0] flags_of(input logic [15:0] v);
        return {v[15], v == 16'h0, !v[15] && v != 16'h0};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one instruction, play memory and register file, check every effect.
    task automatic exec(input logic [15:0] ins, input logic [15:0] pc, input bit poke, input int want_cyc);
        logic [3:0]  op;
        logic [15:0] pcrel, basea, srcv, wv, ptr;
        logic [15:0] e_addr [2];
        logic        e_we [2];
        int          e_n;
        bit          e_wr, st_op;
        string       atag, dtag;
        logic [15:0] l_addr [4];
        logic        l_we [4];
        logic [15:0] l_wd [4];
        int          nacc, nwr, ndone, cyc, busy1;
        logic [2:0]  w_idx;
        logic [15:0] w_dat;
        op    = ins[15:12];
        pcrel = pc + sx9(ins[8:0]);
        basea = regs[ins[8:6]] + sx6(ins[5:0]);
        srcv  = regs[ins[11:9]];
        e_n = 0; e_wr = 0; st_op = 0; wv = '0;
        e_addr[0] = '0; e_addr[1] = '0; e_we[0] = 0; e_we[1] = 0;
        atag = "R1"; dtag = "R5";
        case (op)
            4'b0010: begin e_n = 1; e_addr[0] = pcrel; e_wr = 1; wv = mword(pcrel); end
            4'b0011: begin e_n = 1; e_addr[0] = pcrel; e_we[0] = 1; st_op = 1; dtag = "R6"; end
            4'b1010: begin atag = "R3"; ptr = mword(pcrel); e_n = 2; e_addr[0] = pcrel;
                           e_addr[1] = ptr; e_wr = 1; wv = mword(ptr); end
            4'b1011: begin atag = "R3"; ptr = mword(pcrel); e_n = 2; e_addr[0] = pcrel;
                           e_addr[1] = ptr; e_we[1] = 1; st_op = 1; dtag = "R6"; end
            4'b0110: begin atag = "R2"; e_n = 1; e_addr[0] = basea; e_wr = 1; wv = mword(basea); end
            4'b0111: begin atag = "R2"; dtag = "R6"; e_n = 1; e_addr[0] = basea; e_we[0] = 1; st_op = 1; end
            default: begin dtag = "R4"; e_wr = 1; wv = pcrel; end
        endcase
        nacc = 0; nwr = 0; ndone = 0; cyc = 0; busy1 = 0; w_idx = '0; w_dat = '0;
        @(negedge clk);
        start = 1'b1; instr = ins; npc = pc;
        while (ndone == 0 && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) busy1 = busy;
            start = (cyc == 1) && poke;
            if (cyc == 1 && poke) instr = 16'h3E3F;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (lat == 0) begin
                    mem_ack = 1'b1;
                    mem_rdata = mword(mem_addr);
                    if (nacc < 4) begin
                        l_addr[nacc] = mem_addr; l_we[nacc] = mem_we; l_wd[nacc] = mem_wdata;
                    end
                    nacc++;
                    lat = $urandom % 3;
                end else lat--;
            end
            if (rf_wr_en) begin
                nwr++; w_idx = rf_wr_idx; w_dat = rf_wr_data;
                regs[rf_wr_idx] = rf_wr_data;
            end
            if (done) ndone++;
        end
        start = 1'b0;
        chk(ndone == 1, "R9 done seen", ndone, 1);
        chk(busy1 == 1, "R9 busy after accept", busy1, 1);
        if (want_cyc > 0) chk(cyc == want_cyc, "R4 completion cycle", cyc, want_cyc);
        chk(nacc == e_n, {atag, " access count"}, nacc, e_n);
        for (int k = 0; k < 2; k++) begin
            if (k < e_n && k < nacc) begin
                chk(l_addr[k] == e_addr[k], {atag, " address"}, l_addr[k], e_addr[k]);
                chk(l_we[k] == e_we[k], {dtag, " direction"}, l_we[k], e_we[k]);
                if (e_we[k]) chk(l_wd[k] == srcv, "R6 store data", l_wd[k], srcv);
            end
        end
        chk(nwr == (e_wr ? 1 : 0), {dtag, " write count"}, nwr, e_wr);
        if (e_wr && nwr == 1) begin
            chk(w_idx == ins[11:9], {dtag, " write index"}, w_idx, ins[11:9]);
            chk(w_dat == wv, {dtag, " write data"}, w_dat, wv);
            exp_fl = flags_of(wv);
        end
        @(negedge clk);
        if (mem_ack) mem_ack = 1'b0;
        chk(!done, "R9 done one cycle", done, 0);
        chk({flag_n, flag_z, flag_p} == exp_fl, st_op ? "R7 store keeps flags" : "R7 flags",
            {flag_n, flag_z, flag_p}, exp_fl);
    endtask

    // Pulse start with an undefined opcode and watch that nothing moves.
    task automatic ignored(input logic [3:0] op);
        @(negedge clk);
        start = 1'b1; instr = {op, 12'hA5C}; npc = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(!busy && !mem_req && !done && !rf_wr_en, "R10 undefined opcode ignored",
                {busy, mem_req, done, rf_wr_en}, 0);
            @(negedge clk);
        end
        chk({flag_n, flag_z, flag_p} == exp_fl, "R10 flags untouched", {flag_n, flag_z, flag_p}, exp_fl);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] ops [7];
        void'($urandom(32'h0051_C0DE));
        ops[0] = 4'b0010; ops[1] = 4'b0011; ops[2] = 4'b1010; ops[3] = 4'b1011;
        ops[4] = 4'b0110; ops[5] = 4'b0111; ops[6] = 4'b1110;
        for (int i = 0; i < 8; i++) regs[i] = 16'(($urandom % 65536));
        exp_fl = 3'b010;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !mem_req && !rf_wr_en, "R11 reset outputs",
            {busy, done, mem_req, rf_wr_en}, 0);
        chk({flag_n, flag_z, flag_p} == 3'b010, "R11 reset flags", {flag_n, flag_z, flag_p}, 3'b010);
        rst_n = 1'b1;
        // R1 worked address
        lat = 0;
        @(negedge clk);
        start = 1'b1; instr = {4'b0010, 3'd5, 9'b101000010}; npc = 16'h4012;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(mem_req && mem_addr == 16'h3F54, "R1 worked address x3F54", mem_addr, 16'h3F54);
        mem_ack = 1'b1; mem_rdata = mword(16'h3F54);
        @(negedge clk);
        mem_ack = 1'b0;
        regs[5] = mword(16'h3F54);
        exp_fl = flags_of(regs[5]);
        @(negedge clk);
        @(negedge clk);
        // R4 effective-address form: zero, negative, timing
        exec({4'b1110, 3'd2, 9'h1FB}, 16'h0005, 0, 2);
        chk(flag_z && !flag_n && !flag_p, "R7 zero result", {flag_n, flag_z, flag_p}, 3'b010);
        exec({4'b1110, 3'd3, 9'h001}, 16'h8000, 0, 2);
        chk(flag_n, "R7 negative result", {flag_n, flag_z, flag_p}, 3'b100);
        // R2 base equals source register store; R10 start while busy
        exec({4'b0111, 3'd4, 3'd4, 6'h3E}, 16'h0100, 0, 0);
        exec({4'b0010, 3'd1, 9'h0FF}, 16'hFFF0, 1, 0);
        exec({4'b1011, 3'd6, 9'h100}, 16'h0080, 1, 0);
        ignored(4'b0001); ignored(4'b0000); ignored(4'b1111); ignored(4'b1000);
        // Random mix of all seven forms
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = ops[$urandom % 7];
            exec({op, 12'(($urandom % 4096))}, 16'(($urandom % 65536)), ($urandom % 8) == 0, 0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule